// File: doc/BRIEF.md
# Single I/O Pin with Peripheral Override Muxes

This block is one bidirectional general-purpose pin slice of a microcontroller port. Software sees three locations on a small register bus. The direction bit decides whether the pad driver is on. The port bit supplies the driven level, or enables a weak pull-up when the pin is an input. The pin location returns the synchronized level seen at the pad. A write of 1 to the pin location flips the port bit.

A peripheral that borrows the pin can take over four pad-side decisions: pull-up, driver enable, driven value and digital input enable. Each decision has its own enable/value pair, and the value is used only while its enable is high. The peripheral can also invert the port bit through a toggle input.

The pad level is gated by the input enable, which turns off in sleep unless overridden. The gated level goes raw to the peripheral. It also passes through a latch-plus-flop synchronizer for software readback. A global pull-up disable and the sleep request come from outside the pin.

Top module: `gpio_pin_ovr`

## Requirements
- R1: While reset is held and after its release, the direction and port bits read back as 0 and the pad driver and pull-up outputs are low when no override is active.
- R2: With the pull-up override enable low, padPull is 1 exactly when direction is 0, port is 1 and pullDisable is 0; any other combination of these gives 0.
- R3: With the pull-up override enable high, padPull equals the pull-up override value, whatever the direction, port and pullDisable bits are.
- R4: padOe equals the direction override value while the direction override enable is high, and equals the direction bit otherwise.
- R5: While padOe is 1, padOut equals the output override value if its enable is high, and the port bit otherwise. While padOe is 0, padOut is 0.
- R6: The register bus uses the address encodings 0 = direction, 1 = port, 2 = pin and 3 = unused. A write to address 0 or 1 loads bit PIN_IDX of busWrData into that register on the next rising edge.
- R7: Each rising edge with toggleOvrEn high inverts the port bit. A port write in the same cycle takes precedence, so the written value is loaded and no inversion happens.
- R8: A write to the pin address with bit PIN_IDX set inverts the port bit. A write there with that bit clear, or any write to address 3, leaves both registers unchanged.
- R9: The input is enabled when sleepReq is low, unless the input-enable override enable is high, in which case the override value decides. While the input is disabled, altIn is 0 and the pin readback settles to 0.
- R10: A pad change made while the clock is high shows at the pin readback after the second clock edge (falling, then rising) and not before. A change made while the clock is low shows after the next rising edge.
- R11: busRdBit returns the addressed bit (direction, port or synchronized pin) while busRd is high. It is 0 while busRd is low or when the address is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register select (0 dir, 1 port, 2 pin) |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWrData | input | BUS_W | Write data; bit PIN_IDX is used |
| busRdBit | output | 1 | Read data bit for this pin |
| pullDisable | input | 1 | Global pull-up disable |
| sleepReq | input | 1 | Sleep state, disables input unless overridden |
| pullOvrEn | input | 1 | Pull-up override enable |
| pullOvrVal | input | 1 | Pull-up override value |
| dirOvrEn | input | 1 | Driver enable override enable |
| dirOvrVal | input | 1 | Driver enable override value |
| outOvrEn | input | 1 | Output value override enable |
| outOvrVal | input | 1 | Output value override value |
| toggleOvrEn | input | 1 | Invert port bit on this edge |
| inEnOvrEn | input | 1 | Input enable override enable |
| inEnOvrVal | input | 1 | Input enable override value |
| padIn | input | 1 | Level from the pad receiver |
| padOe | output | 1 | Pad driver enable |
| padOut | output | 1 | Pad driven level |
| padPull | output | 1 | Pad pull-up enable |
| altIn | output | 1 | Gated, unsynchronized input for the peripheral |

## Verification
The only internal state is the direction bit, the port bit and the two synchronizer stages. A wrong direction bit shows on padOe in the cycle after the write whenever no direction override is active. A wrong port bit shows on padOut or padPull in that same cycle, and on a port read. A synchronizer fault appears as readback arriving one edge too early or late around a pad change. It can also appear as a nonzero readback after the input has been disabled for two edges.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DIR  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PORT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PIN  = 2'd2;

  typedef struct packed {
    logic wrDir;
    logic wrPort;
    logic togglePort;
    logic rdDir;
    logic rdPort;
    logic rdPin;
    logic dataBit;
  } ctrlStrobes_t;
endpackage

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pin_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int PIN_IDX = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BUS_W-1:0]  busWrData,
  input  logic              toggleOvrEn,
  output ctrlStrobes_t      strb
);
  logic selDir, selPort, selPin;

  always_comb begin
    selDir  = (busAddr == ADDR_DIR);
    selPort = (busAddr == ADDR_PORT);
    selPin  = (busAddr == ADDR_PIN);
    strb.dataBit    = busWrData[PIN_IDX];
    strb.wrDir      = busWr & selDir;
    strb.wrPort     = busWr & selPort;
    // bus-side flip and peripheral-side flip share one inversion
    strb.togglePort = (busWr & selPin & busWrData[PIN_IDX]) | toggleOvrEn;
    strb.rdDir      = busRd & selDir;
    strb.rdPort     = busRd & selPort;
    strb.rdPin      = busRd & selPin;
  end
endmodule

// File: rtl/gpio_pin_dp.sv
module gpio_pin_dp
  import gpio_pin_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  ctrlStrobes_t strb,
  input  logic         pullDisable,
  input  logic         sleepReq,
  input  logic         pullOvrEn,
  input  logic         pullOvrVal,
  input  logic         dirOvrEn,
  input  logic         dirOvrVal,
  input  logic         outOvrEn,
  input  logic         outOvrVal,
  input  logic         inEnOvrEn,
  input  logic         inEnOvrVal,
  input  logic         padIn,
  output logic         padOe,
  output logic         padOut,
  output logic         padPull,
  output logic         altIn,
  output logic         busRdBit
);
  logic dirQ, portQ;
  logic inEn, gatedIn;
  logic latchQ, pinSync;

  // software-visible registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirQ  <= 1'b0;
      portQ <= 1'b0;
    end else begin
      if (strb.wrDir) dirQ <= strb.dataBit;
      if (strb.wrPort) portQ <= strb.dataBit;
      else if (strb.togglePort) portQ <= ~portQ;
    end
  end

  p_dir_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrDir |=> dirQ == $past(strb.dataBit));
  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.togglePort && !strb.wrPort) |=> portQ != $past(portQ));
  p_port_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.togglePort && !strb.wrPort) |=> portQ == $past(portQ));

  // override multiplexers toward the pad
  always_comb begin
    padOe   = dirOvrEn  ? dirOvrVal  : dirQ;
    padOut  = padOe & (outOvrEn ? outOvrVal : portQ);
    padPull = pullOvrEn ? pullOvrVal : (~dirQ & portQ & ~pullDisable);
    inEn    = inEnOvrEn ? inEnOvrVal : ~sleepReq;
    gatedIn = padIn & inEn;
    altIn   = gatedIn;
  end

  // synchronizer: transparent-low latch, then rising-edge flop
  always_latch begin
    if (!rst_n) latchQ = 1'b0;
    else if (!clk) latchQ = gatedIn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pinSync <= 1'b0;
    else        pinSync <= latchQ;
  end

  always_comb begin
    busRdBit = (strb.rdDir & dirQ) | (strb.rdPort & portQ) | (strb.rdPin & pinSync);
  end

  p_rd_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.rdDir, strb.rdPort, strb.rdPin}));
endmodule

// File: rtl/gpio_pin_ovr.sv
module gpio_pin_ovr
  import gpio_pin_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int PIN_IDX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BUS_W-1:0]  busWrData,
  output logic              busRdBit,
  input  logic              pullDisable,
  input  logic              sleepReq,
  input  logic              pullOvrEn,
  input  logic              pullOvrVal,
  input  logic              dirOvrEn,
  input  logic              dirOvrVal,
  input  logic              outOvrEn,
  input  logic              outOvrVal,
  input  logic              toggleOvrEn,
  input  logic              inEnOvrEn,
  input  logic              inEnOvrVal,
  input  logic              padIn,
  output logic              padOe,
  output logic              padOut,
  output logic              padPull,
  output logic              altIn
);
  ctrlStrobes_t strb;

  gpio_pin_ctrl #(.BUS_W(BUS_W), .PIN_IDX(PIN_IDX)) i_ctrl (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .busWrData(busWrData),
    .toggleOvrEn(toggleOvrEn), .strb(strb)
  );

  gpio_pin_dp i_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .pullDisable(pullDisable), .sleepReq(sleepReq),
    .pullOvrEn(pullOvrEn), .pullOvrVal(pullOvrVal),
    .dirOvrEn(dirOvrEn), .dirOvrVal(dirOvrVal),
    .outOvrEn(outOvrEn), .outOvrVal(outOvrVal),
    .inEnOvrEn(inEnOvrEn), .inEnOvrVal(inEnOvrVal),
    .padIn(padIn), .padOe(padOe), .padOut(padOut), .padPull(padPull),
    .altIn(altIn), .busRdBit(busRdBit)
  );

  p_out_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !padOe |-> !padOut);
endmodule

// File: tb/test_gpio_pin_ovr.sv
module test_gpio_pin_ovr;
  localparam int CLK_PERIOD = 10;
  localparam int BUS_W = 8;
  localparam int PIN_IDX = 3;

  // [dir port pud][puoe puov ddoe][ddov pvoe pvov][expOe expOut expPull]
  localparam logic [11:0] VEC [0:9] = '{
    12'b000_000_000_000,
    12'b010_000_000_001,
    12'b011_000_000_000,
    12'b110_000_000_110,
    12'b100_000_011_110,
    12'b010_100_000_000,
    12'b110_110_000_111,
    12'b000_001_100_100,
    12'b110_001_011_000,
    12'b010_001_100_111
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [BUS_W-1:0] busWrData = '0;
  logic busRdBit;
  logic pullDisable = 0, sleepReq = 0;
  logic pullOvrEn = 0, pullOvrVal = 0, dirOvrEn = 0, dirOvrVal = 0;
  logic outOvrEn = 0, outOvrVal = 0, toggleOvrEn = 0;
  logic inEnOvrEn = 0, inEnOvrVal = 0, padIn = 0;
  logic padOe, padOut, padPull, altIn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pin_ovr #(.BUS_W(BUS_W), .PIN_IDX(PIN_IDX)) i_gpio_pin_ovr (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdBit(busRdBit), .pullDisable(pullDisable),
    .sleepReq(sleepReq), .pullOvrEn(pullOvrEn), .pullOvrVal(pullOvrVal),
    .dirOvrEn(dirOvrEn), .dirOvrVal(dirOvrVal), .outOvrEn(outOvrEn),
    .outOvrVal(outOvrVal), .toggleOvrEn(toggleOvrEn), .inEnOvrEn(inEnOvrEn),
    .inEnOvrVal(inEnOvrVal), .padIn(padIn), .padOe(padOe), .padOut(padOut),
    .padPull(padPull), .altIn(altIn)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [BUS_W-1:0] mk(input logic b, input logic others);
    logic [BUS_W-1:0] d;
    d = {BUS_W{others}};
    d[PIN_IDX] = b;
    return d;
  endfunction

  // called 1 unit after a rising edge; returns 1 unit after the next one
  task automatic busWrite(input logic [1:0] a, input logic [BUS_W-1:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0; busWrData = '0;
  endtask

  task automatic busReadChk(input logic [1:0] a, input logic exp, input string tag);
    busAddr = a; busRd = 1'b1; #1;
    check(tag, busRdBit, exp);
    busRd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 during reset
    #2;
    check("R1 padOe in reset", padOe, 1'b0);
    check("R1 padPull in reset", padPull, 1'b0);
    busReadChk(2'd0, 1'b0, "R1 dir in reset");
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    busReadChk(2'd0, 1'b0, "R1 dir after reset");
    busReadChk(2'd1, 1'b0, "R1 port after reset");

    // table-driven override mux checks (R2 R3 R4 R5)
    for (int i = 0; i < 10; i++) begin
      logic [11:0] v;
      v = VEC[i];
      busWrite(2'd0, mk(v[11], ~v[11]));
      busWrite(2'd1, mk(v[10], ~v[10]));
      pullDisable = v[9]; pullOvrEn = v[8]; pullOvrVal = v[7];
      dirOvrEn = v[6]; dirOvrVal = v[5]; outOvrEn = v[4]; outOvrVal = v[3];
      #1;
      check($sformatf("R4 padOe row %0d", i), padOe, v[2]);
      check($sformatf("R5 padOut row %0d", i), padOut, v[1]);
      check($sformatf("R2,R3 padPull row %0d", i), padPull, v[0]);
      pullDisable = 0; pullOvrEn = 0; pullOvrVal = 0;
      dirOvrEn = 0; dirOvrVal = 0; outOvrEn = 0; outOvrVal = 0;
    end

    // R6 only bit PIN_IDX is used
    busWrite(2'd1, mk(1'b0, 1'b1));
    busReadChk(2'd1, 1'b0, "R6 port ignores other bits");
    busWrite(2'd1, mk(1'b1, 1'b0));
    busReadChk(2'd1, 1'b1, "R6 port loads bit");
    busWrite(2'd0, mk(1'b1, 1'b0));
    busReadChk(2'd0, 1'b1, "R6 dir loads bit");
    busWrite(2'd0, mk(1'b0, 1'b1));
    busReadChk(2'd0, 1'b0, "R6 dir clears");

    // R8 pin-address writes
    busWrite(2'd2, mk(1'b1, 1'b0));
    busReadChk(2'd1, 1'b0, "R8 pin write 1 toggles");
    busWrite(2'd2, mk(1'b0, 1'b1));
    busReadChk(2'd1, 1'b0, "R8 pin write 0 holds");
    busWrite(2'd3, mk(1'b1, 1'b1));
    busReadChk(2'd1, 1'b0, "R8 addr 3 write holds port");
    busReadChk(2'd0, 1'b0, "R8 addr 3 write holds dir");

    // R7 toggle override
    toggleOvrEn = 1'b1;
    @(posedge clk); #1;
    toggleOvrEn = 1'b0;
    busReadChk(2'd1, 1'b1, "R7 single toggle");
    toggleOvrEn = 1'b1;
    repeat (2) @(posedge clk);
    #1 toggleOvrEn = 1'b0;
    busReadChk(2'd1, 1'b1, "R7 two toggles restore");
    toggleOvrEn = 1'b1;
    busWrite(2'd1, mk(1'b1, 1'b0));
    toggleOvrEn = 1'b0;
    busReadChk(2'd1, 1'b1, "R7 port write wins over toggle");

    // R11 read gating
    busAddr = 2'd1; busRd = 1'b0; #1;
    check("R11 no read strobe", busRdBit, 1'b0);
    busReadChk(2'd3, 1'b0, "R11 addr 3 reads 0");

    // R10 latency, change in high phase
    @(posedge clk); #1 padIn = 1'b1;
    busReadChk(2'd2, 1'b0, "R10 no edge yet");
    @(negedge clk);
    busReadChk(2'd2, 1'b0, "R10 after falling edge");
    @(posedge clk);
    busReadChk(2'd2, 1'b1, "R10 after second edge");
    // change in low phase
    @(negedge clk); #1 padIn = 1'b0;
    busReadChk(2'd2, 1'b1, "R10 low phase before edge");
    @(posedge clk);
    busReadChk(2'd2, 1'b0, "R10 low phase after rising edge");

    // R9 input enable
    padIn = 1'b1; sleepReq = 1'b1; #1;
    check("R9 altIn off in sleep", altIn, 1'b0);
    repeat (2) @(posedge clk);
    busReadChk(2'd2, 1'b0, "R9 readback 0 in sleep");
    inEnOvrEn = 1'b1; inEnOvrVal = 1'b1; #1;
    check("R9 override on altIn", altIn, 1'b1);
    repeat (2) @(posedge clk);
    busReadChk(2'd2, 1'b1, "R9 override readback");
    sleepReq = 1'b0; inEnOvrVal = 1'b0; #1;
    check("R9 override off altIn", altIn, 1'b0);
    repeat (2) @(posedge clk);
    busReadChk(2'd2, 1'b0, "R9 override off readback");
    inEnOvrEn = 1'b0; #1;
    check("R9 awake altIn", altIn, 1'b1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule